// File: doc/BRIEF.md
# Register Rename Map with Rollback History

This block translates architectural register numbers into physical register numbers for an out-of-order core. A rename request may carry one destination. An accepted destination takes the oldest register on a free list and becomes the new mapping for its architectural register. The block also logs a history record of {sequence number, architectural register, new physical register, displaced physical register}. A per-physical-register ready bit forms a small scoreboard. Allocation clears that bit and a writeback sets it. The rename port also carries one source lookup, which returns the current mapping and its ready bit.

Recovery and retirement both work on the history log, from opposite ends. A squash to sequence S undoes every record younger than S, newest first. Each undo puts the old mapping back and returns the new register to the free list. A flush undoes every record. A commit of sequence C retires the records at the oldest end that are not younger than C, and each one hands its displaced register back to the free list. Each walk handles one record per clock and raises `busy` while it runs. No rename is accepted while a walk is in progress.

Top module: `reg_rename_map`

## Requirements
- R1: After reset every architectural register a maps to physical register a, every physical register reads ready, `free_count` equals PHYS_REGS-ARCH_REGS, `busy` is low, and the free list hands out ARCH_REGS, ARCH_REGS+1, ... in ascending order.
- R2: An accepted rename with a destination presents the head of the free list on `ren_new_phys` and the displaced mapping on `ren_prev_phys`. From the next cycle the destination maps to the new register and `free_count` is one lower. Registers later returned to the free list are handed out again in the order they were returned.
- R3: A source lookup returns the current mapping and its ready bit. An allocation clears the ready bit of the allocated register, and a writeback (`wb_valid`, `wb_phys`) sets it again one cycle later.
- R4: A request with a destination is refused (`ren_accept` low, no state change) when the free list is empty or the history log is full. A request without a destination is accepted and allocates nothing.
- R5: A squash to S raises `busy` from the next cycle. It then undoes the records whose sequence number is greater than S, newest first, one per cycle. Each undo restores the mapping and appends the undone new register to the free list.
- R6: A squash that finds no younger record, including one on an empty log, leaves every mapping and the free list unchanged.
- R7: A commit of C, issued while idle, retires the oldest records with sequence number at most C, oldest first. Each retired record appends its displaced register to the free list.
- R8: A commit leaves all state unchanged when the log is empty or its oldest record is younger than C.
- R9: A commit is ignored when it arrives in the same cycle as a squash or flush, or while `busy` is high.
- R10: A flush undoes every record in the log, restoring every mapping and freeing every register that the log had allocated.
- R11: No rename is accepted while `busy` is high or in a cycle in which a squash or flush is signalled.
- R12: `free_count` plus the number of live history records always equals PHYS_REGS-ARCH_REGS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ren_valid | input | 1 | Rename request present |
| ren_seq | input | SEQ_W | Sequence number of the request |
| ren_has_dst | input | 1 | Request carries a destination |
| ren_dst_arch | input | log2(ARCH_REGS) | Destination architectural register |
| ren_src_arch | input | log2(ARCH_REGS) | Source architectural register to look up |
| ren_accept | output | 1 | Request is taken this cycle |
| ren_new_phys | output | log2(PHYS_REGS) | Register that would be allocated (free-list head) |
| ren_prev_phys | output | log2(PHYS_REGS) | Current mapping of the destination |
| src_phys | output | log2(PHYS_REGS) | Current mapping of the source |
| src_ready | output | 1 | Ready bit of `src_phys` |
| wb_valid | input | 1 | Writeback marks a register ready |
| wb_phys | input | log2(PHYS_REGS) | Register written back |
| squash_valid | input | 1 | Roll back to `squash_seq` |
| squash_seq | input | SEQ_W | Youngest sequence number that survives |
| flush | input | 1 | Roll back every record |
| commit_valid | input | 1 | Retire up to `commit_seq` |
| commit_seq | input | SEQ_W | Youngest committed sequence number |
| busy | output | 1 | A rollback or retirement walk is running |
| free_count | output | log2(PHYS_REGS-ARCH_REGS+1) | Registers on the free list |

## Verification
The hardest situation to reach from the ports is a free list whose order has been reshuffled. Squashes append registers newest-first, and commits append displaced registers oldest-first, so after mixed recovery the allocation order no longer resembles the reset order. The bench keeps a reference queue and a reference log. It then runs a pseudo-random mix of renames, writebacks, commits, squashes and flushes with monotonically assigned sequence numbers, and checks every allocated register against the head of the reference queue. Commits that collide with a squash, or arrive while a walk is running, are placed deliberately so that state must stay unchanged.

// File: rtl/rmap_pkg.sv
// Shared definitions for the rename map.
// Assumes: nothing beyond a synchronous design context.
package rmap_pkg;
    // Walk controller states: idle, rolling back, retiring.
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_UNDO   = 2'd1,
        ST_RETIRE = 2'd2
    } rmap_state_e;
endpackage

// File: rtl/rmap_free_fifo.sv
// Free physical register list, kept as a circular FIFO.
// Holds at most NPHYS-NARCH entries. Reset fills it with
// NARCH..NPHYS-1 in ascending order.
// Assumes: no pop when empty, no push when full (the conservation of
// registers guarantees the latter).
module rmap_free_fifo #(
    parameter int NARCH = 8,
    parameter int NPHYS = 16,
    localparam int NFREE = NPHYS - NARCH,
    localparam int PW  = $clog2(NPHYS),
    localparam int IW  = (NFREE > 1) ? $clog2(NFREE) : 1,
    localparam int CW  = $clog2(NFREE + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pop,
    input  logic          push,
    input  logic [PW-1:0] push_reg,
    output logic [PW-1:0] head_reg,
    output logic [CW-1:0] count
);
    logic [PW-1:0] slot_q [NFREE];
    logic [IW-1:0] rd_q, wr_q;

    function automatic logic [IW-1:0] nxt(input logic [IW-1:0] p);
        return (p == IW'(NFREE - 1)) ? '0 : p + 1'b1;
    endfunction

    // Slot storage: reset image is the ascending spare registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NFREE; i++) slot_q[i] <= PW'(NARCH + i);
        end else if (push) begin
            slot_q[wr_q] <= push_reg;
        end
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q  <= '0;
            wr_q  <= '0;
            count <= CW'(NFREE);
        end else begin
            if (pop)  rd_q <= nxt(rd_q);
            if (push) wr_q <= nxt(wr_q);
            count <= count + CW'(push) - CW'(pop);
        end
    end

    assign head_reg = slot_q[rd_q];
endmodule

// File: rtl/rmap_history.sv
// Sequence-numbered rename history as a circular buffer.
// New records go in at the newest end. Rollback removes from the
// newest end and retirement removes from the oldest end.
// Assumes: push only when not full, pops only when not empty, and
// push never in the same cycle as a pop.
module rmap_history #(
    parameter int DEPTH = 8,
    parameter int SEQ_W = 16,
    parameter int AW    = 3,
    parameter int PW    = 4,
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [SEQ_W-1:0] push_seq,
    input  logic [AW-1:0]    push_arch,
    input  logic [PW-1:0]    push_new,
    input  logic [PW-1:0]    push_prev,
    input  logic             pop_newest,
    input  logic             pop_oldest,
    output logic [SEQ_W-1:0] yng_seq,
    output logic [AW-1:0]    yng_arch,
    output logic [PW-1:0]    yng_new,
    output logic [PW-1:0]    yng_prev,
    output logic [SEQ_W-1:0] old_seq,
    output logic [PW-1:0]    old_prev,
    output logic [CW-1:0]    count,
    output logic             full
);
    logic [SEQ_W-1:0] seq_q  [DEPTH];
    logic [AW-1:0]    arch_q [DEPTH];
    logic [PW-1:0]    new_q  [DEPTH];
    logic [PW-1:0]    prev_q [DEPTH];
    logic [IW-1:0]    head_q, tail_q, yng_idx;

    function automatic logic [IW-1:0] inc(input logic [IW-1:0] p);
        return (p == IW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    function automatic logic [IW-1:0] dec(input logic [IW-1:0] p);
        return (p == '0) ? IW'(DEPTH - 1) : p - 1'b1;
    endfunction

    assign yng_idx = dec(tail_q);

    // Record storage written at the newest end.
    always_ff @(posedge clk) begin
        if (push) begin
            seq_q[tail_q]  <= push_seq;
            arch_q[tail_q] <= push_arch;
            new_q[tail_q]  <= push_new;
            prev_q[tail_q] <= push_prev;
        end
    end

    // Both ends and the live record count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q <= '0;
            tail_q <= '0;
            count  <= '0;
        end else begin
            if (push)            tail_q <= inc(tail_q);
            else if (pop_newest) tail_q <= yng_idx;
            if (pop_oldest)      head_q <= inc(head_q);
            count <= count + CW'(push) - CW'(pop_newest) - CW'(pop_oldest);
        end
    end

    assign yng_seq  = seq_q[yng_idx];
    assign yng_arch = arch_q[yng_idx];
    assign yng_new  = new_q[yng_idx];
    assign yng_prev = prev_q[yng_idx];
    assign old_seq  = seq_q[head_q];
    assign old_prev = prev_q[head_q];
    assign full     = (count == CW'(DEPTH));
endmodule

// File: rtl/rmap_table.sv
// Architectural-to-physical map plus the per-register ready scoreboard.
// Reset: identity map, all registers ready.
// Assumes: one map write per cycle. When a clear and a set hit the
// same register in one cycle, the clear wins.
module rmap_table #(
    parameter int NARCH = 8,
    parameter int NPHYS = 16,
    localparam int AW = $clog2(NARCH),
    localparam int PW = $clog2(NPHYS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_arch,
    input  logic [PW-1:0] wr_phys,
    input  logic          clr_en,
    input  logic [PW-1:0] clr_phys,
    input  logic          set_en,
    input  logic [PW-1:0] set_phys,
    input  logic [AW-1:0] src_arch,
    output logic [PW-1:0] src_phys,
    output logic          src_ready,
    input  logic [AW-1:0] dst_arch,
    output logic [PW-1:0] dst_cur
);
    logic [PW-1:0]    map_q [NARCH];
    logic [NPHYS-1:0] rdy_q;

    // Mapping storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int a = 0; a < NARCH; a++) map_q[a] <= PW'(a);
        end else if (wr_en) begin
            map_q[wr_arch] <= wr_phys;
        end
    end

    // Scoreboard: writeback sets a bit, allocation clears it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdy_q <= '1;
        end else begin
            if (set_en) rdy_q[set_phys] <= 1'b1;
            if (clr_en) rdy_q[clr_phys] <= 1'b0;
        end
    end

    assign src_phys  = map_q[src_arch];
    assign src_ready = rdy_q[src_phys];
    assign dst_cur   = map_q[dst_arch];
endmodule

// File: rtl/reg_rename_map.sv
// Rename map top. Accepts at most one rename per cycle. Squash, flush
// and commit are walks over the history log, one record per cycle.
// A squash or flush takes over from any walk in progress, and a commit
// starts only from idle.
// Assumes: sequence numbers rise monotonically along the log.
module reg_rename_map
    import rmap_pkg::*;
#(
    parameter int ARCH_REGS  = 8,
    parameter int PHYS_REGS  = 16,
    parameter int HIST_DEPTH = 8,
    parameter int SEQ_W      = 16,
    localparam int AW  = $clog2(ARCH_REGS),
    localparam int PW  = $clog2(PHYS_REGS),
    localparam int FCW = $clog2(PHYS_REGS - ARCH_REGS + 1),
    localparam int HCW = $clog2(HIST_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ren_valid,
    input  logic [SEQ_W-1:0] ren_seq,
    input  logic             ren_has_dst,
    input  logic [AW-1:0]    ren_dst_arch,
    input  logic [AW-1:0]    ren_src_arch,
    output logic             ren_accept,
    output logic [PW-1:0]    ren_new_phys,
    output logic [PW-1:0]    ren_prev_phys,
    output logic [PW-1:0]    src_phys,
    output logic             src_ready,
    input  logic             wb_valid,
    input  logic [PW-1:0]    wb_phys,
    input  logic             squash_valid,
    input  logic [SEQ_W-1:0] squash_seq,
    input  logic             flush,
    input  logic             commit_valid,
    input  logic [SEQ_W-1:0] commit_seq,
    output logic             busy,
    output logic [FCW-1:0]   free_count
);
    rmap_state_e      state_q;
    logic [SEQ_W-1:0] target_q;
    logic             undo_all_q;

    logic [HCW-1:0]   hist_count;
    logic             hist_full;
    logic [SEQ_W-1:0] yng_seq, old_seq;
    logic [AW-1:0]    yng_arch;
    logic [PW-1:0]    yng_new, yng_prev, old_prev, free_head;
    logic             do_alloc, undo_step, retire_step, idle, rollback_req;

    assign idle         = (state_q == ST_IDLE);
    assign rollback_req = squash_valid | flush;
    assign ren_accept   = ren_valid & idle & ~rollback_req &
                          (~ren_has_dst | ((free_count != '0) & ~hist_full));
    assign do_alloc     = ren_accept & ren_has_dst;
    assign undo_step    = (state_q == ST_UNDO) & (hist_count != '0) &
                          (undo_all_q | (yng_seq > target_q));
    assign retire_step  = (state_q == ST_RETIRE) & (hist_count != '0) &
                          (old_seq <= target_q);
    assign busy         = ~idle;
    assign ren_new_phys = free_head;

    rmap_free_fifo #(.NARCH(ARCH_REGS), .NPHYS(PHYS_REGS)) u_free (
        .clk      (clk),
        .rst_n    (rst_n),
        .pop      (do_alloc),
        .push     (undo_step | retire_step),
        .push_reg (undo_step ? yng_new : old_prev),
        .head_reg (free_head),
        .count    (free_count)
    );

    rmap_history #(.DEPTH(HIST_DEPTH), .SEQ_W(SEQ_W), .AW(AW), .PW(PW)) u_hist (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (do_alloc),
        .push_seq   (ren_seq),
        .push_arch  (ren_dst_arch),
        .push_new   (free_head),
        .push_prev  (ren_prev_phys),
        .pop_newest (undo_step),
        .pop_oldest (retire_step),
        .yng_seq    (yng_seq),
        .yng_arch   (yng_arch),
        .yng_new    (yng_new),
        .yng_prev   (yng_prev),
        .old_seq    (old_seq),
        .old_prev   (old_prev),
        .count      (hist_count),
        .full       (hist_full)
    );

    rmap_table #(.NARCH(ARCH_REGS), .NPHYS(PHYS_REGS)) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (do_alloc | undo_step),
        .wr_arch   (undo_step ? yng_arch : ren_dst_arch),
        .wr_phys   (undo_step ? yng_prev : free_head),
        .clr_en    (do_alloc),
        .clr_phys  (free_head),
        .set_en    (wb_valid),
        .set_phys  (wb_phys),
        .src_arch  (ren_src_arch),
        .src_phys  (src_phys),
        .src_ready (src_ready),
        .dst_arch  (ren_dst_arch),
        .dst_cur   (ren_prev_phys)
    );

    // Walk controller: rollback pre-empts everything, commit starts only when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            target_q   <= '0;
            undo_all_q <= 1'b0;
        end else if (rollback_req) begin
            state_q    <= ST_UNDO;
            target_q   <= squash_seq;
            undo_all_q <= flush;
        end else begin
            case (state_q)
                ST_IDLE: if (commit_valid) begin
                    state_q  <= ST_RETIRE;
                    target_q <= commit_seq;
                end
                ST_UNDO:   if (!undo_step)   state_q <= ST_IDLE;
                ST_RETIRE: if (!retire_step) state_q <= ST_IDLE;
                default:   state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/reg_rename_map_checks.sv
// Property checker for reg_rename_map, attached by bind below.
module reg_rename_map_checks #(
    parameter int NFREE = 8,
    parameter int FCW   = 4,
    parameter int HCW   = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           ren_accept,
    input logic           ren_has_dst,
    input logic           squash_valid,
    input logic           flush,
    input logic           busy,
    input logic [FCW-1:0] free_count,
    input logic [HCW-1:0] hist_count
);
    // R12: registers are conserved between the free list and the log.
    a_r12_conserve: assert property (@(posedge clk) disable iff (!rst_n)
        int'(free_count) + int'(hist_count) == NFREE);

    // R4: an allocation never comes from an empty free list.
    a_r4_no_empty_alloc: assert property (@(posedge clk) disable iff (!rst_n)
        (ren_accept && ren_has_dst) |-> (free_count != '0));

    // R11: no rename is taken during a walk or next to a rollback request.
    a_r11_no_rename_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (busy || squash_valid || flush) |-> !ren_accept);

    // R2: each allocation shortens the free list by exactly one.
    a_r2_count_dec: assert property (@(posedge clk) disable iff (!rst_n)
        (ren_accept && ren_has_dst) |=> (free_count == $past(free_count) - 1'b1));

    // R5: a squash starts a walk on the next cycle.
    a_r5_squash_busy: assert property (@(posedge clk) disable iff (!rst_n)
        squash_valid |=> busy);

    // R10: a flush starts a walk on the next cycle.
    a_r10_flush_busy: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> busy);
endmodule

bind reg_rename_map reg_rename_map_checks #(
    .NFREE (PHYS_REGS - ARCH_REGS),
    .FCW   (FCW),
    .HCW   (HCW)
) u_checks (
    .clk          (clk),
    .rst_n        (rst_n),
    .ren_accept   (ren_accept),
    .ren_has_dst  (ren_has_dst),
    .squash_valid (squash_valid),
    .flush        (flush),
    .busy         (busy),
    .free_count   (free_count),
    .hist_count   (hist_count)
);

// File: tb/reg_rename_map_test.sv
module reg_rename_map_test;
    localparam int NA = 8, NP = 16, HD = 8, SW = 16;
    localparam int AW = 3, PW = 4, FCW = 4;

    typedef struct {
        int seq;
        int arch;
        int newp;
        int prevp;
    } hrec_t;

    logic           clk = 1'b0, rst_n = 1'b0;
    logic           ren_valid = 0, ren_has_dst = 0;
    logic [SW-1:0]  ren_seq = '0;
    logic [AW-1:0]  ren_dst_arch = '0, ren_src_arch = '0;
    logic           ren_accept, src_ready, busy;
    logic [PW-1:0]  ren_new_phys, ren_prev_phys, src_phys;
    logic           wb_valid = 0;
    logic [PW-1:0]  wb_phys = '0;
    logic           squash_valid = 0, flush = 0, commit_valid = 0;
    logic [SW-1:0]  squash_seq = '0, commit_seq = '0;
    logic [FCW-1:0] free_count;

    int vectors = 0, errors = 0;
    int m_map[NA];
    int m_rdy[NP];
    int free_q[$];
    hrec_t hist_q[$];

    always #2 clk = ~clk;

    reg_rename_map #(.ARCH_REGS(NA), .PHYS_REGS(NP), .HIST_DEPTH(HD), .SEQ_W(SW)) uut (
        .clk(clk), .rst_n(rst_n), .ren_valid(ren_valid), .ren_seq(ren_seq),
        .ren_has_dst(ren_has_dst), .ren_dst_arch(ren_dst_arch), .ren_src_arch(ren_src_arch),
        .ren_accept(ren_accept), .ren_new_phys(ren_new_phys), .ren_prev_phys(ren_prev_phys),
        .src_phys(src_phys), .src_ready(src_ready), .wb_valid(wb_valid), .wb_phys(wb_phys),
        .squash_valid(squash_valid), .squash_seq(squash_seq), .flush(flush),
        .commit_valid(commit_valid), .commit_seq(commit_seq), .busy(busy),
        .free_count(free_count)
    );

    task automatic check(string req, int act, int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic clear_inputs();
        ren_valid = 0; ren_has_dst = 0; wb_valid = 0;
        squash_valid = 0; flush = 0; commit_valid = 0;
    endtask

    task automatic wait_idle();
        while (busy) step();
    endtask

    // Sweep every architectural register through the lookup port.
    task automatic compare_all(string req);
        for (int a = 0; a < NA; a++) begin
            ren_src_arch = AW'(a);
            #1;
            check(req, src_phys, m_map[a]);
            check(req, src_ready, m_rdy[m_map[a]]);
            step();
        end
        check(req, free_count, free_q.size());
        check(req, busy, 0);
    endtask

    task automatic do_rename(int seq, bit has, int dst, int src);
        bit exp_acc;
        int np;
        exp_acc = !has || (free_q.size() != 0 && hist_q.size() < HD);
        ren_valid = 1; ren_seq = SW'(seq); ren_has_dst = has;
        ren_dst_arch = AW'(dst); ren_src_arch = AW'(src);
        #1;
        check("R4", ren_accept, exp_acc);
        check("R3", src_phys, m_map[src]);
        check("R3", src_ready, m_rdy[m_map[src]]);
        if (exp_acc && has) begin
            check("R2", ren_new_phys, free_q[0]);
            check("R2", ren_prev_phys, m_map[dst]);
        end
        step();
        clear_inputs();
        if (exp_acc && has) begin
            np = free_q.pop_front();
            hist_q.push_back('{seq, dst, np, m_map[dst]});
            m_map[dst] = np;
            m_rdy[np] = 0;
        end
    endtask

    task automatic do_wb(int p);
        wb_valid = 1; wb_phys = PW'(p);
        step();
        clear_inputs();
        m_rdy[p] = 1;
    endtask

    task automatic do_commit(int c);
        commit_valid = 1; commit_seq = SW'(c);
        step();
        clear_inputs();
        wait_idle();
        while (hist_q.size() != 0 && hist_q[0].seq <= c) begin
            free_q.push_back(hist_q[0].prevp);
            void'(hist_q.pop_front());
        end
    endtask

    // Rollback; optional commit alongside or one cycle after (both must be ignored).
    task automatic do_squash(int s, bit fl, bit same_commit, bit late_commit, int cs);
        hrec_t r;
        squash_valid = !fl; flush = fl; squash_seq = SW'(s);
        ren_valid = 1; ren_has_dst = 0;
        if (same_commit) begin commit_valid = 1; commit_seq = SW'(cs); end
        #1;
        check("R11", ren_accept, 0);
        step();
        clear_inputs();
        check(fl ? "R10" : "R5", busy, 1);
        if (late_commit) begin
            commit_valid = 1; commit_seq = SW'(cs);
            ren_valid = 1; ren_has_dst = 1;
            #1;
            check("R11", ren_accept, 0);
            step();
            clear_inputs();
        end
        wait_idle();
        while (hist_q.size() != 0 && (fl || hist_q[hist_q.size()-1].seq > s)) begin
            r = hist_q.pop_back();
            m_map[r.arch] = r.prevp;
            free_q.push_back(r.newp);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        int seq;
        logic [15:0] lf;
        for (int a = 0; a < NA; a++) m_map[a] = a;
        for (int p = 0; p < NP; p++) m_rdy[p] = 1;
        for (int p = NA; p < NP; p++) free_q.push_back(p);
        repeat (3) step();
        rst_n = 1;
        #1;
        check("R1", busy, 0);
        check("R1", free_count, NP - NA);
        compare_all("R1");

        // Fill the log; destinations repeat so prev mappings chain.
        for (int i = 0; i < 8; i++) do_rename(i + 1, 1, (i * 3) % 5, (i + 2) % NA);
        do_rename(9, 1, 2, 2);      // R4: log full / free list empty
        do_rename(9, 0, 0, 1);      // R4: source-only accepted
        compare_all("R2");

        do_wb(m_map[3]);
        do_wb(m_map[1]);
        compare_all("R3");

        do_squash(5, 0, 0, 0, 0);   // R5: undo seq 8,7,6
        compare_all("R5");
        for (int i = 0; i < 3; i++) do_rename(6 + i, 1, (i + 5) % NA, i);
        compare_all("R2");

        do_commit(3);               // R7
        compare_all("R7");
        do_commit(2);               // R8: oldest is younger
        compare_all("R8");
        do_squash(100, 0, 0, 0, 0); // R6: nothing younger
        compare_all("R6");
        do_squash(6, 0, 1, 0, 7);   // R9: commit alongside squash
        compare_all("R9");
        do_squash(100, 0, 0, 1, 50);// R9: commit during walk
        compare_all("R9");
        do_squash(0, 1, 0, 0, 0);   // R10: flush all
        compare_all("R10");
        do_squash(0, 0, 0, 0, 0);   // R6: empty log
        do_commit(1000);            // R8: empty log
        compare_all("R8");

        // Mixed pseudo-random traffic; R12 conservation watched throughout.
        seq = 10;
        lf = 16'hACE1;
        for (int it = 0; it < 600; it++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            case (lf[2:0])
                3'd0, 3'd1, 3'd2, 3'd3: begin
                    seq++;
                    do_rename(seq, lf[3] | lf[4], int'(lf[7:5]), int'(lf[10:8]));
                end
                3'd4: do_wb(int'(lf[11:8]));
                3'd5: do_commit(seq - int'(lf[6:4]));
                3'd6: begin
                    do_squash(seq - int'(lf[5:4]), 0, 0, 0, 0);
                    seq = seq - int'(lf[5:4]);
                end
                default: if (lf[9]) do_squash(0, 1, 0, 0, 0);
                         else do_wb(int'(lf[7:4]));
            endcase
            if (it % 20 == 19) compare_all("R12");
        end
        compare_all("R12");

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule